// File: doc/BRIEF.md
# Power-Domain Segment Control Pair

This block sits in the always-on test domain, immediately ahead of a stretch of a test data register that runs through a separately switched power island. It adds two one-bit scan cells to the register. The first cell reports whether the island is functionally powered and can force the island on. The second cell decides whether the island's stretch of the register is part of the scan path at all.

A multiplexer on the return side picks the serial output. It takes either the tail of the island segment or the tail of the control cell, so a segment whose supply is down never breaks the chain. The control cell captures its own update-stage value, so test software can confirm the path setting. The expected sequence is: write the override, poll the power capture until it reads on, then set the control bit. The test-mode gate sent to the island's boundary cells is qualified by the control bit.

Top module: `seg_pwr_mux_ctrl`

## Requirements
- R1: While `rst_n` is low at a falling edge of `tck`, both update stages clear. Afterwards `pwr_force_o` is 0, `seg_mode_o` is 0, and the short path is selected.
- R2: A `tap_reset_i` strobe clears both update stages at the falling edge, even when `update_i` is high in the same cycle.
- R3: On a capture cycle the power cell loads the synchronised `pwr_sense_i` (1 = island on, 0 = off). The sense input passes through `SENSE_SYNC` rising-edge stages first.
- R4: On a capture cycle the control cell loads the value held in its own update stage.
- R5: Shifting runs `tdi_i` → power cell → control cell. With the segment excluded, the path is exactly 2 bits: the first bit shifted out is the control capture, the second is the power capture, and a bit shifted in appears at `tdo_o` after two shifts.
- R6: With the control update stage at 1, the control cell feeds `seg_tdi_o` and `tdo_o` follows `seg_tdo_i`, so the path is 2 plus the segment length. The bits shifted out first are the segment contents.
- R7: Update stages load from the shift stages only at the falling edge of `tck` in a cycle with `update_i` high. Outputs do not change between that cycle's rising edge and its falling edge.
- R8: Without `update_i` or `tap_reset_i`, the update stages hold. Scanning new bits leaves `pwr_force_o` and `seg_mode_o` unchanged.
- R9: `seg_mode_o` is high only when `test_mode_i` is high and the control update stage is 1. `pwr_force_o` is the power update stage: 1 forces the island on, 0 leaves normal mode.
- R10: When capture and shift are both high in a cycle, capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| tap_reset_i | input | 1 | Test-logic reset strobe |
| capture_i | input | 1 | Capture strobe |
| shift_i | input | 1 | Shift strobe |
| update_i | input | 1 | Update strobe |
| tdi_i | input | 1 | Serial data in |
| pwr_sense_i | input | 1 | Island functionally-on indication |
| test_mode_i | input | 1 | External-test mode to be gated |
| seg_tdo_i | input | 1 | Tail of the island segment |
| pwr_force_o | output | 1 | Power override to the island controller |
| seg_tdi_o | output | 1 | Serial data into the island segment |
| seg_mode_o | output | 1 | Gated test mode to the island's cells |
| tdo_o | output | 1 | Serial data out after the path multiplexer |

## Verification
A reset strobe and an update strobe can land in the same cycle. The bench provokes this by scanning ones into both cells and raising `tap_reset_i` together with `update_i`. It judges the result by the outputs after that falling edge and by a follow-up capture that must read the control bit back as 0 over a 2-bit path. A capture and a shift can also be requested together. The bench preloads ones, raises both strobes with the sense low, and expects zeros to emerge.

// File: rtl/seg_ctl_pkg.sv
// Shared definitions for the segment control pair.
// Assumes: cells are one-bit data registers clocked by the test clock.
package seg_ctl_pkg;
    // Selects what a scan cell loads on a capture cycle.
    typedef enum logic {
        CAP_EXTERNAL = 1'b0,
        CAP_SELF     = 1'b1
    } cap_src_e;

    localparam int unsigned CELL_W_DEF     = 1;
    localparam int unsigned SENSE_SYNC_DEF = 2;
endpackage

// File: rtl/sc_sense_sync.sv
// Brings the island power-sense level into the test clock domain.
// Assumes: the input is a slow level; STAGES = 0 passes it straight through.
module sc_sense_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic tck,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q_o = d_i;
        end else begin : g_chain
            logic [STAGES-1:0] stg_q;
            logic [STAGES:0]   stg_cat;
            assign stg_cat = {stg_q, d_i};
            // Shift the sense level one stage per rising edge.
            always_ff @(posedge tck) begin
                if (!rst_n) stg_q <= '0;
                else        stg_q <= stg_cat[STAGES-1:0];
            end
            assign q_o = stg_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/sc_scan_cell.sv
// Capture/shift/update data register cell.
// Shift stage on the rising edge, update stage on the falling edge.
// Assumes: capture has priority over shift; clr_i or reset clears the update stage.
module sc_scan_cell
    import seg_ctl_pkg::*;
#(
    parameter int unsigned W   = 1,
    parameter cap_src_e    SRC = CAP_EXTERNAL
) (
    input  logic         tck,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         capture_i,
    input  logic         shift_i,
    input  logic         update_i,
    input  logic [W-1:0] pi_i,
    input  logic         si_i,
    output logic         so_o,
    output logic [W-1:0] upd_o
);
    logic [W-1:0] sh_q;
    logic [W-1:0] upd_q;
    logic [W-1:0] cap_d;
    logic [W:0]   sh_cat;

    // Pick the capture source: external observe point or own update stage.
    always_comb begin
        cap_d = (SRC == CAP_SELF) ? upd_q : pi_i;
    end

    assign sh_cat = {sh_q, si_i};

    // Shift stage: capture wins over shift.
    always_ff @(posedge tck) begin
        if (!rst_n)         sh_q <= '0;
        else if (capture_i) sh_q <= cap_d;
        else if (shift_i)   sh_q <= sh_cat[W-1:0];
    end

    // Update stage: reset wins over update, loads on the falling edge.
    always_ff @(negedge tck) begin
        if (!rst_n || clr_i) upd_q <= '0;
        else if (update_i)   upd_q <= sh_q;
    end

    assign so_o  = sh_q[W-1];
    assign upd_o = upd_q;
endmodule

// File: rtl/sc_seg_return.sv
// Return-side path multiplexer and test-mode gate for one island segment.
// Assumes: sel_i comes from the control cell update stage, 1 = segment included.
module sc_seg_return (
    input  logic sel_i,
    input  logic short_i,
    input  logic seg_i,
    input  logic mode_i,
    output logic so_o,
    output logic mode_o
);
    // Choose the serial return path and qualify the test mode.
    always_comb begin
        so_o   = sel_i ? seg_i : short_i;
        mode_o = mode_i & sel_i;
    end
endmodule

// File: rtl/seg_pwr_mux_ctrl.sv
// Power observe/override cell plus path-control cell ahead of one
// switched-island register segment, with the return multiplexer.
// Assumes: strobes come from a standard TAP controller; the island segment
// shifts on the rising edge of tck while shift_i is high.
module seg_pwr_mux_ctrl
    import seg_ctl_pkg::*;
#(
    parameter int unsigned SENSE_SYNC = SENSE_SYNC_DEF
) (
    input  logic tck,
    input  logic rst_n,
    input  logic tap_reset_i,
    input  logic capture_i,
    input  logic shift_i,
    input  logic update_i,
    input  logic tdi_i,
    input  logic pwr_sense_i,
    input  logic test_mode_i,
    input  logic seg_tdo_i,
    output logic pwr_force_o,
    output logic seg_tdi_o,
    output logic seg_mode_o,
    output logic tdo_o
);
    localparam int unsigned CW = CELL_W_DEF;

    logic          sense_s;
    logic          pwr_so;
    logic          ctl_so;
    logic [CW-1:0] pwr_upd;
    logic [CW-1:0] ctl_upd;

    sc_sense_sync #(.STAGES(SENSE_SYNC)) u_sync (
        .tck   (tck),
        .rst_n (rst_n),
        .d_i   (pwr_sense_i),
        .q_o   (sense_s)
    );

    sc_scan_cell #(.W(CW), .SRC(CAP_EXTERNAL)) u_pwr_cell (
        .tck       (tck),
        .rst_n     (rst_n),
        .clr_i     (tap_reset_i),
        .capture_i (capture_i),
        .shift_i   (shift_i),
        .update_i  (update_i),
        .pi_i      (CW'(sense_s)),
        .si_i      (tdi_i),
        .so_o      (pwr_so),
        .upd_o     (pwr_upd)
    );

    sc_scan_cell #(.W(CW), .SRC(CAP_SELF)) u_ctl_cell (
        .tck       (tck),
        .rst_n     (rst_n),
        .clr_i     (tap_reset_i),
        .capture_i (capture_i),
        .shift_i   (shift_i),
        .update_i  (update_i),
        .pi_i      ('0),
        .si_i      (pwr_so),
        .so_o      (ctl_so),
        .upd_o     (ctl_upd)
    );

    sc_seg_return u_ret (
        .sel_i   (ctl_upd[CW-1]),
        .short_i (ctl_so),
        .seg_i   (seg_tdo_i),
        .mode_i  (test_mode_i),
        .so_o    (tdo_o),
        .mode_o  (seg_mode_o)
    );

    assign pwr_force_o = pwr_upd[CW-1];
    assign seg_tdi_o   = ctl_so;
endmodule

// File: rtl/seg_pwr_mux_ctrl_chk.sv
// Temporal checks for the segment control pair, bound into the top module.
module seg_pwr_mux_ctrl_chk (
    input logic tck,
    input logic rst_n,
    input logic tap_reset_i,
    input logic capture_i,
    input logic shift_i,
    input logic update_i,
    input logic sense_s,
    input logic pwr_so,
    input logic ctl_so,
    input logic ctl_sel,
    input logic pwr_force_o,
    input logic seg_mode_o
);
    AST_RESET_CLEARS: assert property (@(negedge tck)
        !rst_n |=> (!pwr_force_o && !ctl_sel)); // R1

    AST_TAP_RESET_WINS: assert property (@(negedge tck) disable iff (!rst_n)
        tap_reset_i |=> (!pwr_force_o && !ctl_sel)); // R2

    AST_POWER_CAPTURE: assert property (@(posedge tck) disable iff (!rst_n)
        capture_i |=> (pwr_so == $past(sense_s))); // R3

    AST_SELF_CAPTURE: assert property (@(posedge tck) disable iff (!rst_n)
        capture_i |=> (ctl_so == $past(ctl_sel))); // R4

    AST_SHIFT_ORDER: assert property (@(posedge tck) disable iff (!rst_n)
        (shift_i && !capture_i) |=> (ctl_so == $past(pwr_so))); // R5

    AST_UPDATE_HOLD: assert property (@(negedge tck) disable iff (!rst_n)
        (!update_i && !tap_reset_i) |=> ($stable(pwr_force_o) && $stable(ctl_sel))); // R8

    AST_MODE_NEEDS_SEL: assert property (@(posedge tck) disable iff (!rst_n)
        seg_mode_o |-> ctl_sel); // R9
endmodule

bind seg_pwr_mux_ctrl seg_pwr_mux_ctrl_chk u_chk (
    .tck         (tck),
    .rst_n       (rst_n),
    .tap_reset_i (tap_reset_i),
    .capture_i   (capture_i),
    .shift_i     (shift_i),
    .update_i    (update_i),
    .sense_s     (sense_s),
    .pwr_so      (pwr_so),
    .ctl_so      (ctl_so),
    .ctl_sel     (ctl_upd[0]),
    .pwr_force_o (pwr_force_o),
    .seg_mode_o  (seg_mode_o)
);

// File: tb/tb_seg_pwr_mux_ctrl.sv
module tb_seg_pwr_mux_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int SEG_LEN    = 4;
    localparam int NVEC       = 6;
    // {sense, ovr_wr, ctl_wr, test_mode, exp_force, exp_mode}
    localparam logic [5:0] VEC [NVEC] = '{
        6'b010110, 6'b111111, 6'b101000,
        6'b000100, 6'b111111, 6'b010110
    };

    logic tck = 1'b0;
    logic rst_n = 1'b0;
    logic tap_reset = 1'b0, capture = 1'b0, shift = 1'b0, update = 1'b0;
    logic tdi = 1'b0, sense = 1'b0, tmode = 1'b0;
    logic seg_tdo, pwr_force, seg_tdi, seg_mode, tdo;
    logic [SEG_LEN-1:0] seg_q = '0;
    int total = 0;
    int bad = 0;
    logic cur_ctl = 1'b0;
    logic [15:0] dout;
    logic [15:0] din;

    always #(CLK_PERIOD/2) tck = ~tck;

    // Island segment model.
    always @(posedge tck) if (shift) seg_q <= {seg_q[SEG_LEN-2:0], seg_tdi};
    assign seg_tdo = seg_q[SEG_LEN-1];

    seg_pwr_mux_ctrl dut (
        .tck(tck), .rst_n(rst_n), .tap_reset_i(tap_reset), .capture_i(capture),
        .shift_i(shift), .update_i(update), .tdi_i(tdi), .pwr_sense_i(sense),
        .test_mode_i(tmode), .seg_tdo_i(seg_tdo), .pwr_force_o(pwr_force),
        .seg_tdi_o(seg_tdi), .seg_mode_o(seg_mode), .tdo_o(tdo)
    );

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge tck);
        #2;
    endtask

    // Capture, shift n bits (din[0] first), optional update with optional reset.
    task automatic dr_scan(input int n, input logic [15:0] di, input logic upd,
                           input logic rst, output logic [15:0] dq);
        dq = '0;
        capture = 1'b1;
        tick();
        capture = 1'b0;
        shift = 1'b1;
        for (int i = 0; i < n; i++) begin
            tdi = di[i];
            #6;
            dq[i] = tdo;
            tick();
        end
        shift = 1'b0;
        if (upd || rst) begin
            update = upd;
            tap_reset = rst;
            tick();
            update = 1'b0;
            tap_reset = 1'b0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tmode = 1'b1;
        repeat (3) tick();
        #6;
        check("R1 force after reset", pwr_force, 1'b0);
        check("R1 mode after reset", seg_mode, 1'b0);
        rst_n = 1'b1;
        tick();

        // R5: 2-bit bypass path, readback order control then power.
        dr_scan(3, 16'b011, 1'b0, 1'b0, dout);
        check("R1 control readback after reset", dout[0], 1'b0);
        check("R5 power readback second", dout[1], 1'b0);
        check("R5 first shifted bit after two shifts", dout[2], 1'b1);

        // Table walk: R3 R4 R9.
        for (int v = 0; v < NVEC; v++) begin
            int n;
            sense = VEC[v][5];
            tmode = VEC[v][2];
            repeat (3) tick();
            n = cur_ctl ? 2 + SEG_LEN : 2;
            din = '0;
            din[n-1] = VEC[v][4];
            din[n-2] = VEC[v][3];
            dr_scan(n, din, 1'b1, 1'b0, dout);
            check("R3 power capture equals sense", dout[n-1], VEC[v][5]);
            check("R4 control capture equals held value", dout[n-2], cur_ctl);
            cur_ctl = VEC[v][3];
            #6;
            check("R9 force output", pwr_force, VEC[v][1]);
            check("R9 gated mode output", seg_mode, VEC[v][0]);
            tick();
        end
        tmode = 1'b1;

        // R10: capture beats shift. Preload ones in bypass (cur_ctl = 0).
        sense = 1'b0;
        repeat (3) tick();
        shift = 1'b1; tdi = 1'b1;
        tick(); tick();
        capture = 1'b1;
        tick();
        capture = 1'b0;
        tdi = 1'b0;
        #6;
        check("R10 control cell took capture", tdo, 1'b0);
        tick();
        #6;
        check("R10 power cell took capture", tdo, 1'b0);
        tick();
        shift = 1'b0;

        // R6: include segment, then verify its contents come out first.
        sense = 1'b1;
        repeat (3) tick();
        dr_scan(2, 16'b11, 1'b1, 1'b0, dout);
        din = 16'b11_1101;
        dr_scan(2 + SEG_LEN, din, 1'b1, 1'b0, dout);
        dr_scan(2 + SEG_LEN, din, 1'b0, 1'b0, dout);
        for (int k = 0; k < SEG_LEN; k++)
            check("R6 segment bit order", dout[k], din[k]);
        check("R6 control capture after segment", dout[SEG_LEN], 1'b1);
        check("R6 power capture last", dout[SEG_LEN+1], 1'b1);

        // R7: update lands on the falling edge only (write force 0, control 1).
        din = 16'b01_0000;
        dr_scan(2 + SEG_LEN, din, 1'b0, 1'b0, dout);
        update = 1'b1;
        #1;
        check("R7 force unchanged before falling edge", pwr_force, 1'b1);
        #5;
        check("R7 force loaded after falling edge", pwr_force, 1'b0);
        check("R7 mode still on", seg_mode, 1'b1);
        tick();
        update = 1'b0;

        // R8: scanning without update changes nothing.
        din = 16'b10_0000;
        dr_scan(2 + SEG_LEN, din, 1'b0, 1'b0, dout);
        repeat (2) tick();
        #6;
        check("R8 force held", pwr_force, 1'b0);
        check("R8 mode held", seg_mode, 1'b1);
        tick();

        // R2: reset strobe in the same cycle as update.
        dr_scan(2 + SEG_LEN, 16'b11_1111, 1'b1, 1'b1, dout);
        #6;
        check("R2 force cleared over update", pwr_force, 1'b0);
        check("R2 mode cleared over update", seg_mode, 1'b0);
        tick();
        dr_scan(3, 16'b100, 1'b0, 1'b0, dout);
        check("R2 control reads back 0", dout[0], 1'b0);
        check("R2 path back to 2 bits", dout[2], 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule